// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Generator

This block raises the three FIFO-related interrupt conditions of a UART channel whose transmit and receive FIFOs hold 64 entries each. It looks at the free-space count of the transmit FIFO and the fill count of the receive FIFO. It compares each count against an effective trigger level and presents the result as level flags that follow the counts in the same cycle. Each flag is gated by its own enable input.

An 8-bit trigger register holds one nibble per direction, and each nibble is scaled by four. When a nibble is zero, that direction falls back to a fixed level picked by a 2-bit legacy select field. The effective levels are also driven out, for use by neighbouring flow-control logic.

A separate receive-timeout timer counts character periods. It is advanced by a one-cycle pulse from the baud logic and raises a flag when data has waited in the receive FIFO for a set number of character times. The trigger level plays no part in this timer.

Top module: `fifo_trig_irq`

## Requirements
- R1: When bits [3:0] of `trig_reg` are non-zero, `tx_level` equals that nibble times 4 (4 to 60).
- R2: When bits [7:4] of `trig_reg` are non-zero, `rx_level` equals that nibble times 4 (4 to 60).
- R3: When bits [3:0] of `trig_reg` are zero, `tx_level` comes from `tx_legacy_sel` as follows: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56.
- R4: When bits [7:4] of `trig_reg` are zero, `rx_level` comes from `rx_legacy_sel` as follows: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60.
- R5: `tx_ready_irq` is high in the same cycle that `tx_free` >= `tx_level` and `tx_int_en` is high, and low otherwise.
- R6: `rx_ready_irq` is high in the same cycle that `rx_fill` >= `rx_level` and `rx_int_en` is high, and low otherwise.
- R7: While `rx_fill` is non-zero and no push or pop occurs, `rx_timeout_irq` rises in the cycle after the clock edge that samples the 4th `char_tick` pulse. It stays low after only 3 pulses.
- R8: A cycle with `rx_push` or `rx_pop` high restarts the timeout count from zero and clears a pending timeout.
- R9: `rx_timeout_irq` is low whenever `rx_fill` is zero, and an empty FIFO resets the count.
- R10: The timeout fires whether `rx_fill` is below or above `rx_level`.
- R11: When `to_int_en` is low, `rx_timeout_irq` stays low. The timer keeps running, so raising the enable shows an already expired timeout at once.
- R12: After reset, the timeout count is zero and `rx_timeout_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_reg | input | 8 | Trigger nibbles: [7:4] receive, [3:0] transmit |
| tx_legacy_sel | input | 2 | Fallback transmit level select |
| rx_legacy_sel | input | 2 | Fallback receive level select |
| tx_free | input | 7 | Free entries in the transmit FIFO (0..64) |
| rx_fill | input | 7 | Occupied entries in the receive FIFO (0..64) |
| rx_push | input | 1 | A character was written into the receive FIFO this cycle |
| rx_pop | input | 1 | A character was read from the receive FIFO this cycle |
| char_tick | input | 1 | One-cycle pulse once per character time |
| tx_int_en | input | 1 | Transmit-ready enable |
| rx_int_en | input | 1 | Receive-data-ready enable |
| to_int_en | input | 1 | Receive-timeout enable |
| tx_ready_irq | output | 1 | Transmit-ready condition |
| rx_ready_irq | output | 1 | Receive-data-ready condition |
| rx_timeout_irq | output | 1 | Receive-timeout condition |
| tx_level | output | 7 | Effective transmit trigger level |
| rx_level | output | 7 | Effective receive trigger level |

## Verification
The assertions assume that both FIFO counts never exceed the FIFO depth of 64. They also assume that `rx_fill` moves in step with the push and pop pulses, although the timer itself only relies on the pulses. The directed stimulus keeps every count in the range 0 to 64. It raises a push or pop pulse whenever it starts a new timeout window, and it drives `char_tick` as single-cycle pulses with idle cycles between them, as a baud divider would.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
   // Fallback transmit level for a zero nibble
   function automatic int unsigned tx_fallback(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return 56;
      endcase
   endfunction

   // Fallback receive level for a zero nibble
   function automatic int unsigned rx_fallback(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 56;
         default: return 60;
      endcase
   endfunction
endpackage

// File: rtl/trig_level_sel.sv
module trig_level_sel #(
   parameter int NIB_W  = 4,
   parameter int CNT_W  = 7,
   parameter int SCALE  = 4,
   parameter bit IS_RX  = 1'b0
) (
   input  logic [NIB_W-1:0] nibble,
   input  logic [1:0]       legacy_sel,
   output logic [CNT_W-1:0] level
);
   import fifo_trig_pkg::*;

   logic [CNT_W-1:0] fallback;
   logic [CNT_W-1:0] scaled;

   generate
      if (IS_RX) begin : g_rx_tab
         always_comb fallback = CNT_W'(rx_fallback(legacy_sel));
      end else begin : g_tx_tab
         always_comb fallback = CNT_W'(tx_fallback(legacy_sel));
      end
   endgenerate

   always_comb begin
      scaled = CNT_W'(32'(nibble) * SCALE);
      level  = (nibble != '0) ? scaled : fallback;
   end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int CNT_W    = 7,
   parameter int TO_CHARS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_fill,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             char_tick,
   output logic             expired
);
   localparam int TO_W = $clog2(TO_CHARS + 1);

   logic [TO_W-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks <= '0;
      end else if (rx_fill == '0 || rx_push || rx_pop) begin
         ticks <= '0;
      end else if (char_tick && ticks != TO_W'(TO_CHARS)) begin
         ticks <= ticks + 1'b1;
      end
   end

   assign expired = (ticks == TO_W'(TO_CHARS));
endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq #(
   parameter int FIFO_DEPTH = 64,
   parameter int TRIG_W     = 8,
   parameter int TO_CHARS   = 4,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
   localparam int NIB_W     = TRIG_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIG_W-1:0] trig_reg,
   input  logic [1:0]        tx_legacy_sel,
   input  logic [1:0]        rx_legacy_sel,
   input  logic [CNT_W-1:0]  tx_free,
   input  logic [CNT_W-1:0]  rx_fill,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              char_tick,
   input  logic              tx_int_en,
   input  logic              rx_int_en,
   input  logic              to_int_en,
   output logic              tx_ready_irq,
   output logic              rx_ready_irq,
   output logic              rx_timeout_irq,
   output logic [CNT_W-1:0]  tx_level,
   output logic [CNT_W-1:0]  rx_level
);
   generate
      if (FIFO_DEPTH < 60) begin : g_depth_chk
         $error("FIFO_DEPTH must cover the largest trigger level of 60");
      end
      if (TRIG_W % 2 != 0) begin : g_trig_chk
         $error("TRIG_W must be even");
      end
      if (TO_CHARS < 1) begin : g_to_chk
         $error("TO_CHARS must be at least 1");
      end
   endgenerate

   logic to_expired;

   trig_level_sel #(.NIB_W(NIB_W), .CNT_W(CNT_W), .SCALE(4), .IS_RX(1'b0)) u_tx_sel (
      .nibble     (trig_reg[NIB_W-1:0]),
      .legacy_sel (tx_legacy_sel),
      .level      (tx_level)
   );

   trig_level_sel #(.NIB_W(NIB_W), .CNT_W(CNT_W), .SCALE(4), .IS_RX(1'b1)) u_rx_sel (
      .nibble     (trig_reg[TRIG_W-1:NIB_W]),
      .legacy_sel (rx_legacy_sel),
      .level      (rx_level)
   );

   rx_idle_timer #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_fill   (rx_fill),
      .rx_push   (rx_push),
      .rx_pop    (rx_pop),
      .char_tick (char_tick),
      .expired   (to_expired)
   );

   always_comb begin
      tx_ready_irq   = tx_int_en && (tx_free >= tx_level);
      rx_ready_irq   = rx_int_en && (rx_fill >= rx_level);
      rx_timeout_irq = to_int_en && to_expired && (rx_fill != '0);
   end
endmodule

// File: rtl/fifo_trig_irq_chk.sv
module fifo_trig_irq_chk #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       trig_reg,
   input logic [CNT_W-1:0] tx_free,
   input logic [CNT_W-1:0] rx_fill,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             tx_int_en,
   input logic             rx_int_en,
   input logic             to_int_en,
   input logic             tx_ready_irq,
   input logic             rx_ready_irq,
   input logic             rx_timeout_irq,
   input logic [CNT_W-1:0] tx_level,
   input logic [CNT_W-1:0] rx_level
);
   AST_TX_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level[1:0] == 2'b00 && tx_level != '0 && tx_level <= 60)); // R1
   AST_RX_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level[1:0] == 2'b00 && rx_level != '0 && rx_level <= 60)); // R2
   AST_TX_NIB_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_reg[3:0] != 4'd0) |-> (tx_level[5:2] == trig_reg[3:0])); // R1
   AST_TX_IRQ_OK: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_irq |-> (tx_int_en && tx_free >= tx_level)); // R5
   AST_RX_IRQ_OK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready_irq |-> (rx_int_en && rx_fill >= rx_level)); // R6
   AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push || rx_pop) |=> !rx_timeout_irq); // R8
   AST_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fill == '0) |-> !rx_timeout_irq); // R9
   AST_TO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !to_int_en |-> !rx_timeout_irq); // R11
endmodule

bind fifo_trig_irq fifo_trig_irq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fifo_trig_irq_tb.sv
module fifo_trig_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] trig_reg = 8'h00;
   logic [1:0] tx_legacy_sel = 2'd0, rx_legacy_sel = 2'd0;
   logic [6:0] tx_free = 7'd0, rx_fill = 7'd0;
   logic       rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
   logic       tx_int_en = 1'b1, rx_int_en = 1'b1, to_int_en = 1'b1;
   logic       tx_ready_irq, rx_ready_irq, rx_timeout_irq;
   logic [6:0] tx_level, rx_level;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fifo_trig_irq u_dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic tick_chars(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); char_tick = 1'b1;
         @(negedge clk); char_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_push();
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic t_reset();
      rx_fill = 7'd3;
      settle();
      check("R12 timeout low in reset", rx_timeout_irq, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R12 timeout low after reset", rx_timeout_irq, 0);
      rx_fill = 7'd0;
   endtask

   task automatic t_scaled();
      for (int nib = 1; nib < 16; nib++) begin
         @(negedge clk);
         trig_reg = {4'(16 - nib), 4'(nib)};
         settle();
         check("R1 tx scaled level", tx_level, nib * 4);
         check("R2 rx scaled level", rx_level, (16 - nib) * 4);
      end
   endtask

   task automatic t_legacy();
      int tx_tab[4] = '{8, 16, 32, 56};
      int rx_tab[4] = '{8, 16, 56, 60};
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         trig_reg = 8'h00;
         tx_legacy_sel = 2'(s);
         rx_legacy_sel = 2'(3 - s);
         settle();
         check("R3 tx legacy level", tx_level, tx_tab[s]);
         check("R4 rx legacy level", rx_level, rx_tab[3 - s]);
      end
      @(negedge clk);
      trig_reg = 8'h50;
      tx_legacy_sel = 2'd2;
      settle();
      check("R3 tx legacy with rx nibble set", tx_level, 32);
      check("R2 rx nibble beats legacy", rx_level, 20);
   endtask

   task automatic t_compare();
      @(negedge clk);
      trig_reg = 8'h43;
      tx_int_en = 1'b1;
      rx_int_en = 1'b1;
      tx_free = 7'd11;
      rx_fill = 7'd15;
      settle();
      check("R5 tx below level", tx_ready_irq, 0);
      check("R6 rx below level", rx_ready_irq, 0);
      tx_free = 7'd12;
      rx_fill = 7'd16;
      settle();
      check("R5 tx at level", tx_ready_irq, 1);
      check("R6 rx at level", rx_ready_irq, 1);
      tx_free = 7'd64;
      rx_fill = 7'd64;
      settle();
      check("R5 tx full free", tx_ready_irq, 1);
      check("R6 rx full", rx_ready_irq, 1);
      tx_int_en = 1'b0;
      rx_int_en = 1'b0;
      settle();
      check("R5 tx disabled", tx_ready_irq, 0);
      check("R6 rx disabled", rx_ready_irq, 0);
      tx_int_en = 1'b1;
      rx_int_en = 1'b1;
      rx_fill = 7'd0;
      tx_free = 7'd0;
   endtask

   task automatic t_timeout();
      trig_reg = 8'hF1;
      rx_fill = 7'd2;
      pulse_push();
      tick_chars(3);
      check("R7 no timeout after 3 ticks", rx_timeout_irq, 0);
      tick_chars(1);
      check("R7 timeout after 4 ticks", rx_timeout_irq, 1);
      check("R10 timeout below rx level", rx_ready_irq, 0);
      tick_chars(2);
      check("R7 timeout holds", rx_timeout_irq, 1);
   endtask

   task automatic t_restart();
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      check("R8 pop clears timeout", rx_timeout_irq, 0);
      tick_chars(2);
      pulse_push();
      tick_chars(3);
      check("R8 push restarts count", rx_timeout_irq, 0);
      tick_chars(1);
      check("R8 fires after full window", rx_timeout_irq, 1);
   endtask

   task automatic t_empty();
      @(negedge clk); rx_fill = 7'd0;
      settle();
      check("R9 empty drops timeout", rx_timeout_irq, 0);
      tick_chars(5);
      @(negedge clk); rx_fill = 7'd1;
      settle();
      check("R9 empty reset count", rx_timeout_irq, 0);
      tick_chars(3);
      check("R9 count from zero", rx_timeout_irq, 0);
      tick_chars(1);
      check("R9 expires after refill", rx_timeout_irq, 1);
   endtask

   task automatic t_above_and_gate();
      trig_reg = 8'h11;
      rx_fill = 7'd40;
      pulse_push();
      to_int_en = 1'b0;
      tick_chars(4);
      check("R11 timeout gated", rx_timeout_irq, 0);
      to_int_en = 1'b1;
      settle();
      check("R11 enable shows expiry", rx_timeout_irq, 1);
      check("R10 above level both set", rx_ready_irq, 1);
   endtask

   initial begin
      t_reset();
      t_scaled();
      t_legacy();
      t_compare();
      t_timeout();
      t_restart();
      t_empty();
      t_above_and_gate();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule